// File: doc/BRIEF.md
# Carry Chain Shadow Sequencer

This decode-side block lets a single carry-modifier instruction steer the carry behaviour of the ordinary instructions that follow it. When the modifier is decoded, its 16-bit immediate is loaded into a shift register. Each later ordinary instruction leaving decode takes the lowest 2-bit field of that register as its carry tag, and the register then moves right by one field. The tag says whether the instruction reads the chained carry, writes it, does both, or does neither. The immediate holds eight fields, so one modifier covers eight instructions.

The carry passed between covered instructions is a full 64-bit word, not a single flag bit. Execution units return it on a result bus. The block keeps it in a private register and hands it back as an operand to the next instruction that consumes it, so no register-file write port is needed. A multiword add or multiply can therefore be chained as a run of ordinary instructions under one modifier. A pipeline flush drops both the remaining tags and the held carry.

Top module: `carry_shadow_seq`

## Requirements
- R1: After reset, `tag_o` is 00 and `cin_o` is zero, even when an ordinary instruction is decoded.
- R2: In the cycle a modifier is decoded (`mod_valid_i` high), `tag_o` is 00. The next ordinary decoded instruction receives immediate bits [1:0], the one after that bits [3:2], and so on, lowest field first.
- R3: Tag encoding: bit 0 means consume the carry and bit 1 means produce it (00 none, 01 consume, 10 produce, 11 both). `cin_o` carries the held carry value when tag bit 0 is 1, and is zero otherwise.
- R4: A modifier covers exactly 8 ordinary decoded instructions. The ninth and later ones get tag 00.
- R5: Cycles in which `dec_valid_i` is low do not consume a field and do not count toward the 8.
- R6: When the remaining fields are all zero, including an all-zero immediate, every following instruction gets tag 00.
- R7: A modifier decoded while a shadow is active discards the remaining fields, loads its own immediate and restarts the count of 8.
- R8: `flush_i` forces `tag_o` to 00 in its own cycle. It also clears the remaining fields and sets the held carry to zero for the cycles after it.
- R9: A valid carry-out result (`cout_valid_i`) replaces the full 64-bit held carry, and the held value stays unchanged until the next valid result or a flush.
- R10: With the bypass option enabled (default), a consuming instruction decoded in the same cycle as a valid carry-out result receives that result's data on `cin_o`.
- R11: When a flush and a modifier arrive in the same cycle, the flush wins and no shadow is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Pipeline flush: clears the shadow and the held carry |
| dec_valid_i | input | 1 | An ordinary instruction is in the decode slot this cycle |
| mod_valid_i | input | 1 | The decode slot holds a carry modifier this cycle |
| mod_imm_i | input | 16 | Immediate of the carry modifier: eight 2-bit tags |
| cout_valid_i | input | 1 | Carry-out result bus holds a valid value |
| cout_data_i | input | 64 | Carry-out result value |
| tag_o | output | 2 | Carry tag for the instruction decoded this cycle |
| cin_o | output | 64 | Carry operand for the instruction decoded this cycle |

## Verification
Assertions check the following on every cycle: a modifier load fills the shift register and the remaining count, the register moves by exactly one field per consuming decode and holds still otherwise, a flush empties all state, the held carry changes only on a valid result, and the modifier and flush slots always carry tag 00. Only the bench scenarios can show the visible sequences. These are the exact tag order drawn from a given immediate, the cut-off after the eighth instruction across idle gaps, the restart when a second modifier replaces the first, the forwarding of a same-cycle carry result, and the cleared carry seen by the first consumer after a flush.

// File: rtl/carry_shadow_pkg.sv
package carry_shadow_pkg;

   // width of one per-instruction carry tag
   localparam int unsigned CS_TAG_W = 2;

   // bit positions inside a tag
   localparam int unsigned CS_USE_BIT  = 0;
   localparam int unsigned CS_MAKE_BIT = 1;

   typedef enum logic [CS_TAG_W-1:0] {
      CT_NONE = 2'b00,
      CT_USE  = 2'b01,
      CT_MAKE = 2'b10,
      CT_BOTH = 2'b11
   } carry_tag_e;

   function automatic logic tag_reads_carry(input logic [CS_TAG_W-1:0] t);
      return t[CS_USE_BIT];
   endfunction

endpackage

// File: rtl/cs_field_shifter.sv
module cs_field_shifter
   import carry_shadow_pkg::*;
#(
   parameter int unsigned IMM_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_i,
   input  logic                load_i,
   input  logic [IMM_W-1:0]    imm_i,
   input  logic                step_i,
   output logic [CS_TAG_W-1:0] field_o,
   output logic                active_o
);

   localparam int unsigned SLOTS = IMM_W / CS_TAG_W;
   localparam int unsigned CNT_W = $clog2(SLOTS + 1);
   localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

   if ((IMM_W % CS_TAG_W) != 0 || IMM_W < CS_TAG_W) begin : g_bad_imm_w
      $error("cs_field_shifter: IMM_W must be a nonzero multiple of the tag width");
   end

   logic [IMM_W-1:0] sr_q;
   logic [CNT_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         left_q <= '0;
      end else if (flush_i) begin
         sr_q   <= '0;
         left_q <= '0;
      end else if (load_i) begin
         sr_q   <= imm_i;
         left_q <= SLOTS_C;
      end else if (step_i && left_q != '0) begin
         sr_q   <= sr_q >> CS_TAG_W;
         left_q <= left_q - 1'b1;
      end
   end

   assign active_o = (left_q != '0) && (sr_q != '0);
   assign field_o  = active_o ? sr_q[CS_TAG_W-1:0] : '0;

   // R2: a modifier fills the register and restarts the count
   p_load_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !flush_i) |=> (sr_q == $past(imm_i) && left_q == SLOTS_C));

   // R5: no decode, no modifier, no flush -> shadow frozen
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i && !flush_i) |=> ($stable(sr_q) && $stable(left_q)));

   // R4: never more than SLOTS fields outstanding
   p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
      left_q <= SLOTS_C);

   // R4: a step consumes exactly one field
   p_one_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !flush_i && left_q != '0)
      |=> (left_q == $past(left_q) - 1'b1));

   // R8: flush empties the shadow
   p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (left_q == '0 && !active_o));

endmodule

// File: rtl/cs_carry_link.sv
module cs_carry_link #(
   parameter int unsigned CARRY_W = 64,
   parameter bit          BYPASS  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic               res_valid_i,
   input  logic [CARRY_W-1:0] res_data_i,
   output logic [CARRY_W-1:0] link_o
);

   if (CARRY_W < 1) begin : g_bad_carry_w
      $error("cs_carry_link: CARRY_W must be at least 1");
   end

   logic [CARRY_W-1:0] carry_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           carry_q <= '0;
      else if (flush_i)     carry_q <= '0;
      else if (res_valid_i) carry_q <= res_data_i;
   end

   if (BYPASS) begin : g_fwd
      assign link_o = res_valid_i ? res_data_i : carry_q;
   end else begin : g_reg
      assign link_o = carry_q;
   end

   // R9: held carry changes only on a valid result or a flush
   p_carry_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!res_valid_i && !flush_i) |=> $stable(carry_q));

   // R9: full-width capture of a valid result
   p_carry_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid_i && !flush_i) |=> (carry_q == $past(res_data_i)));

   // R8: flush zeroes the held carry
   p_carry_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (carry_q == '0));

endmodule

// File: rtl/cs_tag_issue.sv
module cs_tag_issue
   import carry_shadow_pkg::*;
#(
   parameter int unsigned CARRY_W = 64
) (
   input  logic                slot_valid_i,
   input  logic [CS_TAG_W-1:0] field_i,
   input  logic [CARRY_W-1:0]  link_i,
   output logic [CS_TAG_W-1:0] tag_o,
   output logic [CARRY_W-1:0]  cin_o
);

   always_comb begin
      tag_o = slot_valid_i ? field_i : CT_NONE;
      cin_o = tag_reads_carry(tag_o) ? link_i : '0;
   end

endmodule

// File: rtl/carry_shadow_seq.sv
module carry_shadow_seq
   import carry_shadow_pkg::*;
#(
   parameter int unsigned IMM_W   = 16,
   parameter int unsigned CARRY_W = 64,
   parameter bit          BYPASS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                flush_i,
   input  logic                dec_valid_i,
   input  logic                mod_valid_i,
   input  logic [IMM_W-1:0]    mod_imm_i,
   input  logic                cout_valid_i,
   input  logic [CARRY_W-1:0]  cout_data_i,
   output logic [CS_TAG_W-1:0] tag_o,
   output logic [CARRY_W-1:0]  cin_o
);

   logic                slot_valid;
   logic                load;
   logic [CS_TAG_W-1:0] field;
   logic                active;
   logic [CARRY_W-1:0]  link;

   // an ordinary instruction that may take a tag this cycle
   assign slot_valid = dec_valid_i && !mod_valid_i && !flush_i;
   assign load       = mod_valid_i && !flush_i;

   cs_field_shifter #(.IMM_W(IMM_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (flush_i),
      .load_i   (load),
      .imm_i    (mod_imm_i),
      .step_i   (slot_valid),
      .field_o  (field),
      .active_o (active)
   );

   cs_carry_link #(.CARRY_W(CARRY_W), .BYPASS(BYPASS)) u_link (
      .clk         (clk),
      .rst_n       (rst_n),
      .flush_i     (flush_i),
      .res_valid_i (cout_valid_i),
      .res_data_i  (cout_data_i),
      .link_o      (link)
   );

   cs_tag_issue #(.CARRY_W(CARRY_W)) u_issue (
      .slot_valid_i (slot_valid),
      .field_i      (field),
      .link_i       (link),
      .tag_o        (tag_o),
      .cin_o        (cin_o)
   );

   // R2: the modifier itself is never tagged
   p_mod_untagged_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mod_valid_i |-> (tag_o == CT_NONE));

   // R8: a flushed slot is never tagged
   p_flush_untagged_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> (tag_o == CT_NONE && cin_o == '0));

   // R3: no carry operand without the consume bit
   p_cin_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !tag_o[CS_USE_BIT] |-> (cin_o == '0));

   // R6: an idle shadow gives no tag
   p_idle_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (tag_o == CT_NONE));

   if (BYPASS) begin : g_fwd_chk
      // R10: a same-cycle result reaches the consumer
      p_bypass_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (cout_valid_i && tag_o[CS_USE_BIT]) |-> (cin_o == cout_data_i));
   end

endmodule

// File: tb/carry_shadow_seq_bench.sv
module carry_shadow_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush_i = 1'b0;
   logic        dec_valid_i = 1'b0;
   logic        mod_valid_i = 1'b0;
   logic [15:0] mod_imm_i = '0;
   logic        cout_valid_i = 1'b0;
   logic [63:0] cout_data_i = '0;
   logic [1:0]  tag_o;
   logic [63:0] cin_o;

   int total = 0;
   int bad = 0;

   localparam logic [63:0] VAL_A = 64'hDEAD_BEEF_0123_4567;
   localparam logic [63:0] VAL_B = 64'h8000_0000_0000_0001;

   always #4 clk = ~clk;

   carry_shadow_seq u_carry_shadow_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush_i),
      .dec_valid_i  (dec_valid_i),
      .mod_valid_i  (mod_valid_i),
      .mod_imm_i    (mod_imm_i),
      .cout_valid_i (cout_valid_i),
      .cout_data_i  (cout_data_i),
      .tag_o        (tag_o),
      .cin_o        (cin_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one decode slot (called just after a falling edge), settle
   task automatic slot(input logic dv, input logic mv, input logic [15:0] imm,
                       input logic cv, input logic [63:0] cd, input logic fl);
      dec_valid_i  = dv;
      mod_valid_i  = mv;
      mod_imm_i    = imm;
      cout_valid_i = cv;
      cout_data_i  = cd;
      flush_i      = fl;
      #1;
   endtask

   task automatic adv();
      @(negedge clk);
      dec_valid_i = 1'b0; mod_valid_i = 1'b0; cout_valid_i = 1'b0; flush_i = 1'b0;
   endtask

   task automatic do_flush();
      slot(1'b0, 1'b0, '0, 1'b0, '0, 1'b1); adv();
   endtask

   task automatic t_reset();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R1 tag", {62'b0, tag_o}, 64'd0);
      chk("R1 cin", cin_o, 64'd0);
      adv();
   endtask

   task automatic t_order();
      slot(1'b1, 1'b1, 16'hE4E4, 1'b0, '0, 1'b0);
      chk("R2 modifier slot tag", {62'b0, tag_o}, 64'd0);
      adv();
      for (int i = 0; i < 8; i++) begin
         slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
         chk("R2 field order", {62'b0, tag_o}, 64'(i % 4));
         adv();
      end
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R4 ninth untagged", {62'b0, tag_o}, 64'd0);
      adv();
   endtask

   task automatic t_gaps();
      slot(1'b0, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0); adv();
      for (int i = 0; i < 8; i++) begin
         slot(1'b0, 1'b0, '0, 1'b0, '0, 1'b0); adv();
         slot(1'b0, 1'b0, '0, 1'b0, '0, 1'b0); adv();
         slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
         chk("R5 idle gaps keep field", {62'b0, tag_o}, 64'd3);
         adv();
      end
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R4 cut-off after gaps", {62'b0, tag_o}, 64'd0);
      adv();
   endtask

   task automatic t_carry();
      do_flush();
      slot(1'b0, 1'b0, '0, 1'b1, VAL_A, 1'b0); adv();
      // fields low first: 01,00,10,11,01
      slot(1'b0, 1'b1, 16'h01E1, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R3 consume tag", {62'b0, tag_o}, 64'd1);
      chk("R3 consume cin", cin_o, VAL_A);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R3 none cin", cin_o, 64'd0);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R3 produce tag", {62'b0, tag_o}, 64'd2);
      chk("R3 produce cin", cin_o, 64'd0);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R3 both tag", {62'b0, tag_o}, 64'd3);
      chk("R9 held carry", cin_o, VAL_A);
      adv();
      slot(1'b1, 1'b0, '0, 1'b1, VAL_B, 1'b0);
      chk("R10 bypass cin", cin_o, VAL_B);
      adv();
      slot(1'b0, 1'b1, 16'h0001, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R9 captured full width", cin_o, VAL_B);
      adv();
   endtask

   task automatic t_replace();
      slot(1'b0, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0); adv();
      for (int i = 0; i < 3; i++) begin
         slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0); adv();
      end
      slot(1'b0, 1'b1, 16'h5555, 1'b0, '0, 1'b0); adv();
      for (int i = 0; i < 8; i++) begin
         slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
         chk("R7 replaced fields", {62'b0, tag_o}, 64'd1);
         adv();
      end
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R7 count restarted", {62'b0, tag_o}, 64'd0);
      adv();
   endtask

   task automatic t_zero();
      slot(1'b0, 1'b1, 16'h0000, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R6 zero immediate", {62'b0, tag_o}, 64'd0);
      adv();
      slot(1'b0, 1'b1, 16'h0006, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R6 first field", {62'b0, tag_o}, 64'd2);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R6 second field", {62'b0, tag_o}, 64'd1);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R6 zero remainder", {62'b0, tag_o}, 64'd0);
      adv();
   endtask

   task automatic t_flush();
      slot(1'b0, 1'b0, '0, 1'b1, VAL_A, 1'b0); adv();
      slot(1'b0, 1'b1, 16'hFFFF, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b1);
      chk("R8 flush slot tag", {62'b0, tag_o}, 64'd0);
      adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R8 shadow cleared", {62'b0, tag_o}, 64'd0);
      adv();
      slot(1'b0, 1'b1, 16'h0001, 1'b0, '0, 1'b0); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R8 carry cleared tag", {62'b0, tag_o}, 64'd1);
      chk("R8 carry cleared cin", cin_o, 64'd0);
      adv();
   endtask

   task automatic t_flush_mod();
      slot(1'b0, 1'b1, 16'hFFFF, 1'b0, '0, 1'b1); adv();
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R11 flush beats modifier", {62'b0, tag_o}, 64'd0);
      adv();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      slot(1'b1, 1'b0, '0, 1'b0, '0, 1'b0);
      chk("R1 tag in reset", {62'b0, tag_o}, 64'd0);
      rst_n = 1'b1;
      adv();
      t_reset();
      t_order();
      t_gaps();
      t_carry();
      t_replace();
      t_zero();
      t_flush();
      t_flush_mod();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule